// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This unit settles a conditional branch that covers a whole vector of elements instead of one condition bit. After a start pulse it walks an element index from zero up to the vector length, one element per clock. For each element that the predicate mask enables, it reads a 4-bit condition field from an external condition-field file and tests one bit of that field against an expected value. An element that the mask disables does not read the file. It uses a fixed stand-in bit instead.

The per-element results are combined in one of two modes. In ALL mode, the first failing element ends the walk. In ANY mode, the first passing element ends it. When the walk ends early, the unit can shorten the vector length at the deciding element. The write-back enable comes from instruction bit 16 in the register-target form and from bit 30 in the immediate-target form. When it is set, the unit copies each enabled element's condition bits into condition field number i. A one-cycle done pulse presents the taken flag, the new vector length and the final element index. Target address computation and instruction fetch are handled elsewhere.

Top module: `vbc_eval`

## Requirements
- R1: After reset, done, busy, taken, cf_wr_en, vl_out and elem_idx are all 0.
- R2: With step_mode = 0, every element reads field index {cf_ext, bi[4:2]}. The tested bit is cf_rd_data[bi[1:0]], and an element passes when that bit equals expect_bit.
- R3: With step_mode = 1, element i reads field index ({cf_ext, bi[4:2]} + i) modulo 128. Because write-back is in force, a read sees any write made by an earlier element of the same walk.
- R4: When pred_mask[i] = 0, element i uses masked_val as its tested bit and writes nothing back.
- R5: In ALL mode (mode_all = 1), the walk stops at the first failing element. taken is the result of the last element evaluated, and is 0 when vl_in = 0.
- R6: In ANY mode (mode_all = 0), the walk stops at the first passing element. taken is the result of the last element evaluated, and is 1 when vl_in = 0.
- R7: Elements take one cycle each. If start is raised in cycle 0 and the walk ends at element d, done is high in cycle d+2, or in cycle 1 when vl_in = 0. done is high for exactly one cycle, and busy is low while it is high.
- R8: The write-back enable is insn_b16 when form_sel = 1 and insn_b30 when form_sel = 0. While it is set, each enabled element i drives cf_wr_en with cf_wr_idx = i and cf_wr_data equal to the field it read.
- R9: If vl_set_en = 1 and the walk stopped on the mode's exit condition at element d, vl_out is d+1 when taken = 0 and d when taken = 1. In every other case, vl_out equals vl_in.
- R10: With step_mode = 1, elem_idx is d after an early stop and vl_in after a full walk. With step_mode = 0, elem_idx is 0.
- R11: A start pulse raised while busy = 1 has no effect on the running walk or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation; all configuration inputs are sampled here |
| form_sel | input | 1 | 1 = register-target form, 0 = immediate-target form |
| insn_b30 | input | 1 | Instruction bit 30 (write-back enable in immediate form) |
| insn_b16 | input | 1 | Instruction bit 16 (write-back enable in register form) |
| bi | input | 5 | Branch bit-index field |
| cf_ext | input | 4 | Extension bits that widen bi[4:2] into a 7-bit field index |
| expect_bit | input | 1 | Value the tested bit must have for an element to pass |
| mode_all | input | 1 | 1 = ALL mode, 0 = ANY mode |
| step_mode | input | 1 | Step the field index per element and report the element index |
| vl_set_en | input | 1 | Allow vector-length truncation at the deciding element |
| masked_val | input | 1 | Tested bit used for masked-out elements |
| vl_in | input | 5 | Vector length, 0..16 |
| pred_mask | input | 16 | Per-element predicate |
| cf_rd_idx | output | 7 | Condition-field read index |
| cf_rd_data | input | 4 | Condition field at cf_rd_idx, same cycle |
| cf_wr_en | output | 1 | Condition-field write strobe |
| cf_wr_idx | output | 7 | Condition-field write index |
| cf_wr_data | output | 4 | Condition-field write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| vl_out | output | 5 | Updated vector length |
| elem_idx | output | 5 | Final element index |

## Verification
The checker assumes that cf_rd_data is a same-cycle function of cf_rd_idx and that a write strobed at one edge is visible to the next read. It also assumes vl_in never exceeds the maximum vector length when start is accepted. The bench models the condition-field file as a combinational-read, clocked-write array, which meets the first two assumptions. It draws vector lengths only from 0 to 16. Configuration is sampled only at accepted start pulses, so the bench may change inputs freely between runs. The stray start pulses it injects for R11 arrive only while busy is high.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

   typedef enum logic {
      FORM_IMM = 1'b0,
      FORM_REG = 1'b1
   } form_e;

   // choose the write-back enable bit according to the instruction form
   function automatic logic rc_pick(form_e f, logic b30, logic b16);
      return (f == FORM_REG) ? b16 : b30;
   endfunction

   // true when this element decides the walk under the given mode
   function automatic logic stop_here(logic all_mode, logic el_ok);
      return all_mode ? !el_ok : el_ok;
   endfunction

endpackage

// File: rtl/vbc_ctl.sv
module vbc_ctl
   import vbc_pkg::*;
#(
   parameter int MAXVL = 16,
   parameter int VL_W  = 5,
   parameter int BI_W  = 5,
   parameter int EXT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             form_sel,
   input  logic             insn_b30,
   input  logic             insn_b16,
   input  logic [BI_W-1:0]  bi,
   input  logic [EXT_W-1:0] cf_ext,
   input  logic             expect_bit,
   input  logic             mode_all,
   input  logic             step_mode,
   input  logic             vl_set_en,
   input  logic             masked_val,
   input  logic [VL_W-1:0]  vl_in,
   input  logic [MAXVL-1:0] pred_mask,
   input  logic             fin,
   output logic             busy,
   output logic [VL_W-1:0]  idx,
   output logic [BI_W-1:0]  bi_q,
   output logic [EXT_W-1:0] ext_q,
   output logic             expect_q,
   output logic             all_q,
   output logic             step_q,
   output logic             vlset_q,
   output logic             masked_q,
   output logic             rc_q,
   output logic [VL_W-1:0]  vl_q,
   output logic [MAXVL-1:0] pred_q,
   output logic             zero_go
);

   logic accept;

   assign accept  = start && !busy;
   assign zero_go = accept && (vl_in == '0);

   // configuration capture: only an accepted start touches these
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bi_q     <= '0;
         ext_q    <= '0;
         expect_q <= 1'b0;
         all_q    <= 1'b0;
         step_q   <= 1'b0;
         vlset_q  <= 1'b0;
         masked_q <= 1'b0;
         rc_q     <= 1'b0;
         vl_q     <= '0;
         pred_q   <= '0;
      end else if (accept) begin
         bi_q     <= bi;
         ext_q    <= cf_ext;
         expect_q <= expect_bit;
         all_q    <= mode_all;
         step_q   <= step_mode;
         vlset_q  <= vl_set_en;
         masked_q <= masked_val;
         rc_q     <= rc_pick(form_e'(form_sel), insn_b30, insn_b16);
         vl_q     <= vl_in;
         pred_q   <= pred_mask;
      end
   end

   // element walk
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (accept) begin
         busy <= (vl_in != '0);
         idx  <= '0;
      end else if (busy) begin
         if (fin) begin
            busy <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/vbc_elem.sv
module vbc_elem
   import vbc_pkg::*;
#(
   parameter int MAXVL    = 16,
   parameter int VL_W     = 5,
   parameter int BI_W     = 5,
   parameter int EXT_W    = 4,
   parameter int CF_IW    = 7,
   parameter int CF_W     = 4,
   parameter bit HAS_STEP = 1'b1
) (
   input  logic             busy,
   input  logic [VL_W-1:0]  idx,
   input  logic [BI_W-1:0]  bi_q,
   input  logic [EXT_W-1:0] ext_q,
   input  logic             expect_q,
   input  logic             all_q,
   input  logic             step_q,
   input  logic             masked_q,
   input  logic             rc_q,
   input  logic [VL_W-1:0]  vl_q,
   input  logic [MAXVL-1:0] pred_q,
   input  logic [CF_W-1:0]  cf_rd_data,
   output logic [CF_IW-1:0] cf_rd_idx,
   output logic             cf_wr_en,
   output logic [CF_IW-1:0] cf_wr_idx,
   output logic [CF_W-1:0]  cf_wr_data,
   output logic             el_ok,
   output logic             early,
   output logic             fin
);

   logic [CF_IW-1:0] base_idx;
   logic             pred_bit;
   logic             read_bit;
   logic             test_bit;
   logic             last_el;

   assign base_idx = {ext_q, bi_q[BI_W-1:2]};

   generate
      if (HAS_STEP) begin : g_step
         always_comb begin
            if (step_q) begin
               cf_rd_idx = base_idx + CF_IW'(idx);
            end else begin
               cf_rd_idx = base_idx;
            end
         end
      end else begin : g_fixed
         assign cf_rd_idx = base_idx;
      end
   endgenerate

   assign pred_bit = pred_q[idx];
   assign read_bit = cf_rd_data[bi_q[1:0]];
   assign test_bit = pred_bit ? read_bit : masked_q;
   assign el_ok    = (test_bit == expect_q);
   assign early    = busy && stop_here(all_q, el_ok);
   assign last_el  = (idx == vl_q - 1'b1);
   assign fin      = busy && (early || last_el);

   assign cf_wr_en   = busy && pred_bit && rc_q;
   assign cf_wr_idx  = CF_IW'(idx);
   assign cf_wr_data = cf_rd_data;

endmodule

// File: rtl/vbc_result.sv
module vbc_result #(
   parameter int VL_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fin,
   input  logic            el_ok,
   input  logic            early,
   input  logic [VL_W-1:0] idx,
   input  logic [VL_W-1:0] vl_q,
   input  logic            vlset_q,
   input  logic            step_q,
   input  logic            zero_go,
   input  logic            mode_all,
   output logic            done,
   output logic            taken,
   output logic [VL_W-1:0] vl_out,
   output logic [VL_W-1:0] elem_idx
);

   logic [VL_W-1:0] vl_next;
   logic [VL_W-1:0] idx_next;

   always_comb begin
      if (vlset_q && early) begin
         vl_next = el_ok ? idx : idx + 1'b1;
      end else begin
         vl_next = vl_q;
      end
      if (step_q) begin
         idx_next = early ? idx : vl_q;
      end else begin
         idx_next = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         taken    <= 1'b0;
         vl_out   <= '0;
         elem_idx <= '0;
      end else if (zero_go) begin
         done     <= 1'b1;
         taken    <= !mode_all;
         vl_out   <= '0;
         elem_idx <= '0;
      end else if (fin) begin
         done     <= 1'b1;
         taken    <= el_ok;
         vl_out   <= vl_next;
         elem_idx <= idx_next;
      end else begin
         done <= 1'b0;
      end
   end

endmodule

// File: rtl/vbc_eval.sv
module vbc_eval #(
   parameter int MAXVL    = 16,
   parameter int CF_DEPTH = 128,
   parameter int CF_W     = 4,
   parameter int BI_W     = 5,
   parameter bit HAS_STEP = 1'b1,
   localparam int VL_W    = $clog2(MAXVL + 1),
   localparam int CF_IW   = $clog2(CF_DEPTH),
   localparam int EXT_W   = CF_IW - (BI_W - 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             form_sel,
   input  logic             insn_b30,
   input  logic             insn_b16,
   input  logic [BI_W-1:0]  bi,
   input  logic [EXT_W-1:0] cf_ext,
   input  logic             expect_bit,
   input  logic             mode_all,
   input  logic             step_mode,
   input  logic             vl_set_en,
   input  logic             masked_val,
   input  logic [VL_W-1:0]  vl_in,
   input  logic [MAXVL-1:0] pred_mask,
   output logic [CF_IW-1:0] cf_rd_idx,
   input  logic [CF_W-1:0]  cf_rd_data,
   output logic             cf_wr_en,
   output logic [CF_IW-1:0] cf_wr_idx,
   output logic [CF_W-1:0]  cf_wr_data,
   output logic             busy,
   output logic             done,
   output logic             taken,
   output logic [VL_W-1:0]  vl_out,
   output logic [VL_W-1:0]  elem_idx
);

   generate
      if (CF_W != 4) begin : g_bad_cfw
         $error("vbc_eval: CF_W must be 4");
      end
      if ((1 << CF_IW) != CF_DEPTH) begin : g_bad_depth
         $error("vbc_eval: CF_DEPTH must be a power of two");
      end
      if (MAXVL > CF_DEPTH) begin : g_bad_vl
         $error("vbc_eval: MAXVL must not exceed CF_DEPTH");
      end
      if (EXT_W < 1) begin : g_bad_ext
         $error("vbc_eval: BI_W too wide for CF_DEPTH");
      end
   endgenerate

   logic [VL_W-1:0]  idx;
   logic [BI_W-1:0]  bi_q;
   logic [EXT_W-1:0] ext_q;
   logic             expect_q;
   logic             all_q;
   logic             step_q;
   logic             vlset_q;
   logic             masked_q;
   logic             rc_q;
   logic [VL_W-1:0]  vl_q;
   logic [MAXVL-1:0] pred_q;
   logic             zero_go;
   logic             el_ok;
   logic             early;
   logic             fin;

   vbc_ctl #(
      .MAXVL(MAXVL), .VL_W(VL_W), .BI_W(BI_W), .EXT_W(EXT_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .form_sel(form_sel),
      .insn_b30(insn_b30), .insn_b16(insn_b16), .bi(bi), .cf_ext(cf_ext),
      .expect_bit(expect_bit), .mode_all(mode_all), .step_mode(step_mode),
      .vl_set_en(vl_set_en), .masked_val(masked_val), .vl_in(vl_in),
      .pred_mask(pred_mask), .fin(fin), .busy(busy), .idx(idx),
      .bi_q(bi_q), .ext_q(ext_q), .expect_q(expect_q), .all_q(all_q),
      .step_q(step_q), .vlset_q(vlset_q), .masked_q(masked_q), .rc_q(rc_q),
      .vl_q(vl_q), .pred_q(pred_q), .zero_go(zero_go)
   );

   vbc_elem #(
      .MAXVL(MAXVL), .VL_W(VL_W), .BI_W(BI_W), .EXT_W(EXT_W),
      .CF_IW(CF_IW), .CF_W(CF_W), .HAS_STEP(HAS_STEP)
   ) u_elem (
      .busy(busy), .idx(idx), .bi_q(bi_q), .ext_q(ext_q),
      .expect_q(expect_q), .all_q(all_q), .step_q(step_q),
      .masked_q(masked_q), .rc_q(rc_q), .vl_q(vl_q), .pred_q(pred_q),
      .cf_rd_data(cf_rd_data), .cf_rd_idx(cf_rd_idx), .cf_wr_en(cf_wr_en),
      .cf_wr_idx(cf_wr_idx), .cf_wr_data(cf_wr_data), .el_ok(el_ok),
      .early(early), .fin(fin)
   );

   vbc_result #(
      .VL_W(VL_W)
   ) u_result (
      .clk(clk), .rst_n(rst_n), .fin(fin), .el_ok(el_ok), .early(early),
      .idx(idx), .vl_q(vl_q), .vlset_q(vlset_q), .step_q(step_q),
      .zero_go(zero_go), .mode_all(mode_all), .done(done), .taken(taken),
      .vl_out(vl_out), .elem_idx(elem_idx)
   );

endmodule

// File: rtl/vbc_eval_chk.sv
module vbc_eval_chk #(
   parameter int VL_W  = 5,
   parameter int CF_IW = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             cf_wr_en,
   input logic [CF_IW-1:0] cf_wr_idx,
   input logic [VL_W-1:0]  idx,
   input logic [VL_W-1:0]  vl_q,
   input logic             vlset_q,
   input logic             step_q,
   input logic [VL_W-1:0]  vl_out,
   input logic [VL_W-1:0]  elem_idx
);

   p_wr_in_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cf_wr_en |-> busy);

   p_wr_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cf_wr_en |-> (cf_wr_idx == CF_IW'(idx)));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(vl_q) && $stable(step_q)));

   p_vl_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !vlset_q) |-> (vl_out == vl_q));

   p_vl_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (vl_out <= vl_q));

   p_idx_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !step_q) |-> (elem_idx == '0));

endmodule

bind vbc_eval vbc_eval_chk #(.VL_W(VL_W), .CF_IW(CF_IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .cf_wr_en(cf_wr_en), .cf_wr_idx(cf_wr_idx), .idx(idx), .vl_q(vl_q),
   .vlset_q(vlset_q), .step_q(step_q), .vl_out(vl_out), .elem_idx(elem_idx)
);

// File: tb/vbc_eval_test.sv
module vbc_eval_test;

   localparam int MAXVL = 16;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        form_sel = 1'b0;
   logic        insn_b30 = 1'b0;
   logic        insn_b16 = 1'b0;
   logic [4:0]  bi = '0;
   logic [3:0]  cf_ext = '0;
   logic        expect_bit = 1'b0;
   logic        mode_all = 1'b0;
   logic        step_mode = 1'b0;
   logic        vl_set_en = 1'b0;
   logic        masked_val = 1'b0;
   logic [4:0]  vl_in = '0;
   logic [15:0] pred_mask = '0;
   logic [6:0]  cf_rd_idx;
   logic [3:0]  cf_rd_data;
   logic        cf_wr_en;
   logic [6:0]  cf_wr_idx;
   logic [3:0]  cf_wr_data;
   logic        busy;
   logic        done;
   logic        taken;
   logic [4:0]  vl_out;
   logic [4:0]  elem_idx;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   // condition-field file: same-cycle read, clocked write, bulk load
   logic [3:0] cr   [DEPTH];
   logic [3:0] seed [DEPTH];
   logic [3:0] mcr  [DEPTH];
   logic       ld_all = 1'b0;

   assign cf_rd_data = cr[cf_rd_idx];

   always @(posedge clk) begin
      if (ld_all) begin
         for (int j = 0; j < DEPTH; j++) cr[j] <= seed[j];
      end else if (cf_wr_en) begin
         cr[cf_wr_idx] <= cf_wr_data;
      end
   end

   always #2 clk = ~clk;

   vbc_eval uut (
      .clk(clk), .rst_n(rst_n), .start(start), .form_sel(form_sel),
      .insn_b30(insn_b30), .insn_b16(insn_b16), .bi(bi), .cf_ext(cf_ext),
      .expect_bit(expect_bit), .mode_all(mode_all), .step_mode(step_mode),
      .vl_set_en(vl_set_en), .masked_val(masked_val), .vl_in(vl_in),
      .pred_mask(pred_mask), .cf_rd_idx(cf_rd_idx), .cf_rd_data(cf_rd_data),
      .cf_wr_en(cf_wr_en), .cf_wr_idx(cf_wr_idx), .cf_wr_data(cf_wr_data),
      .busy(busy), .done(done), .taken(taken), .vl_out(vl_out),
      .elem_idx(elem_idx)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // one evaluation with its reference computed from the requirements
   task automatic run_one(input bit disturb);
      int  base, d, lat, exp_lat, exp_vl, exp_idx, mism;
      bit  rc, cond, early, pbit, tbit, ok;
      logic [3:0] bits;

      for (int j = 0; j < DEPTH; j++) begin
         seed[j] = 4'($urandom);
         mcr[j]  = seed[j];
      end
      @(negedge clk);
      ld_all = 1'b1;
      @(negedge clk);
      ld_all = 1'b0;

      // reference walk (R2..R6, R8)
      rc    = form_sel ? insn_b16 : insn_b30;                // R8 enable pick
      base  = {cf_ext, bi[4:2]};
      cond  = !mode_all;                                     // R5/R6 empty vector
      early = 1'b0;
      d     = (vl_in == 0) ? 0 : int'(vl_in) - 1;
      for (int i = 0; i < int'(vl_in); i++) begin
         pbit = pred_mask[i];
         bits = mcr[step_mode ? ((base + i) % DEPTH) : base];  // R2 / R3
         tbit = pbit ? bits[bi[1:0]] : masked_val;             // R4
         ok   = (tbit == expect_bit);
         if (pbit && rc) mcr[i] = bits;
         cond = ok;
         if (mode_all ? !ok : ok) begin
            early = 1'b1;
            d = i;
            break;
         end
      end
      exp_lat = (vl_in == 0) ? 1 : d + 2;
      exp_vl  = (vl_set_en && early) ? (cond ? d : d + 1) : int'(vl_in);
      exp_idx = step_mode ? (early ? d : int'(vl_in)) : 0;

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      if (disturb && busy) begin
         // R11: stray start with a different configuration
         start = 1'b1;
         mode_all = !mode_all;
         vl_in = 5'd1;
         step_mode = !step_mode;
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      while (!done && lat < 64) begin
         @(negedge clk);
         lat++;
      end
      chk(lat == exp_lat, "R7 latency", lat, exp_lat);
      chk(taken == cond, mode_all ? "R5 taken" : "R6 taken", int'(taken), int'(cond));
      if (disturb) chk(taken == cond, "R11 stray start", int'(taken), int'(cond));
      chk(vl_out == 5'(exp_vl), "R9 vl_out", int'(vl_out), exp_vl);
      chk(elem_idx == 5'(exp_idx), "R10 elem_idx", int'(elem_idx), exp_idx);
      @(negedge clk);
      chk(!done && !busy, "R7 single done", int'(done), 0);
      mism = 0;
      for (int j = 0; j < DEPTH; j++) if (cr[j] !== mcr[j]) mism++;
      chk(mism == 0, "R8 write-back contents", mism, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && !busy && !taken && !cf_wr_en && vl_out == 0 && elem_idx == 0,
          "R1 reset state", int'(done) + int'(busy) + int'(taken), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int m = 0; m < 32; m++) begin
         for (int v = 0; v <= MAXVL; v++) begin
            mode_all   = m[0];
            step_mode  = m[1];
            vl_set_en  = m[2];
            form_sel   = m[3];
            masked_val = m[4];
            insn_b30   = 1'($urandom);
            insn_b16   = 1'($urandom);
            bi         = 5'($urandom);
            cf_ext     = 4'($urandom);
            expect_bit = 1'($urandom);
            vl_in      = 5'(v);
            case ($urandom % 4)
               0: pred_mask = '0;
               1: pred_mask = '1;
               default: pred_mask = 16'($urandom);
            endcase
            run_one(v >= 2 && (v % 3 == 0));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule